// File: doc/BRIEF.md
# CAN Bit Timing Logic

This block turns a time-quantum enable pulse into the segment structure of a CAN bit. Each bit opens with a sync segment of exactly one quantum. A first segment of programmable length follows, and the bit closes with a programmable second segment. The sample point sits at the end of the first segment. There the block raises a one-clock strobe and updates the received bit value. The value is either the single bus level at that point or the majority of three levels taken on consecutive quanta.

The receive line is sampled on every quantum tick. A recessive-to-dominant transition between two ticks is treated as an edge:

- While the bus is flagged idle, an edge hard-synchronizes the bit counter.
- Otherwise, the first edge of a bit moves the sample point by at most the programmed jump width. An edge in the first segment lengthens that segment. An edge in the second segment shortens it.

A transmit-point strobe marks the start of every bit's sync segment, so a transmitter can launch its next bit there. Configuration is held stable while the bus is active. The two segment lengths are captured each time the sync segment ends.

Top module: `can_bt_top`

## Requirements
- R1: After reset, seg_id reads 0, sample_stb and tx_stb are low and rx_bit is 1 (recessive).
- R2: seg_id encodes the quantum in progress as 0 = sync, 1 = first segment, 2 = second segment. It never reads 3 and changes only after a clock with tq_tick high. A sync quantum always lasts exactly one tick and is followed by the first segment.
- R3: Without edges, and with triple_en low, the first segment lasts seg1_cfg+1 quanta and the second lasts seg2_cfg+1 quanta. A bit is therefore seg1_cfg+seg2_cfg+3 quanta long.
- R4: tx_stb is high for one clock, the clock after the tick that starts a sync quantum, and at no other time.
- R5: With triple_en low, sample_stb pulses in the clock after the tick that ends the last first-segment quantum. In the same clock, rx_bit takes the rx_in level seen at that tick.
- R6: With triple_en high, the first segment is 2 quanta longer. rx_bit becomes the majority of the rx_in levels seen at the ticks ending the last three first-segment quanta.
- R7: An edge is rx_in 1 at one tick and 0 at the next. A 0-to-1 change never alters timing.
- R8: An edge while bus_idle is 1 makes the quantum in which it occurred the sync segment. The next quantum is the first of the first segment, with no sample or transmit strobe for that quantum and no further correction in that bit.
- R9: With bus_idle 0, the first edge of a bit arriving in the k-th first-segment quantum lengthens that segment by min(k, sjw_cfg+1). The 2-bit field sjw_cfg encodes jump widths 1 to 4.
- R10: With bus_idle 0, the first edge of a bit arriving in a second-segment quantum with r quanta after it shortens the second segment by min(r, sjw_cfg+1). When that removes all r, the next quantum is a sync quantum.
- R11: Only one correction is made per bit. An edge in the sync quantum causes none but still uses up that bit's correction.
- R12: rx_bit changes only in a clock where sample_stb is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tq_tick | input | 1 | One-clock pulse ending each time quantum |
| rx_in | input | 1 | Receive line, 1 = recessive |
| bus_idle | input | 1 | High while the bus is idle, enabling hard synchronization |
| seg1_cfg | input | 4 | First segment length minus one |
| seg2_cfg | input | 3 | Second segment length minus one |
| sjw_cfg | input | 2 | Jump width minus one |
| triple_en | input | 1 | 1 = three samples with majority vote, 0 = one sample |
| seg_id | output | 2 | Segment of the quantum in progress |
| sample_stb | output | 1 | One-clock pulse at each sample point |
| rx_bit | output | 1 | Bit value taken at the latest sample point |
| tx_stb | output | 1 | One-clock pulse at the start of each sync quantum |

## Verification
A corrupted segment index or length shows on seg_id on the next tick. It shows on the spacing of tx_stb pulses within one bit time. A lost or stale correction flag shows as a second timing shift within the same bit, visible as a wrong bit length at the following tx_stb. A wrong sample history shows on rx_bit at the very next sample strobe. Since every one of these is visible within one bit time, the bench compares seg_id, both strobes and rx_bit against a reference model on every clock. It also measures bit lengths between transmit strobes for the correction cases.

// File: rtl/can_bt_pkg.sv
// Shared types for the CAN bit timing logic.
// Assumes: nothing beyond the encodings defined here.
package can_bt_pkg;

    // Segment of the quantum in progress; the encoding appears on the seg_id port.
    typedef enum logic [1:0] {
        SEG_SYNC   = 2'd0,
        SEG_FIRST  = 2'd1,
        SEG_SECOND = 2'd2
    } seg_e;

    // Two-out-of-three majority of three bus levels.
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/can_bt_edge.sv
// Falling-edge detector on the receive line, evaluated only at quantum ticks.
// Assumes: rx_in is already synchronized to clk; the line idles recessive (1).
module can_bt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tq_tick,
    input  logic rx_in,
    output logic fall_edge
);

    logic prev_q;

    // Hold the bus level seen at the most recent tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else if (tq_tick) begin
            prev_q <= rx_in;
        end
    end

    // Recessive at the previous tick, dominant now.
    assign fall_edge = tq_tick & prev_q & ~rx_in;

endmodule

// File: rtl/can_bt_seq.sv
// Segment sequencer: walks sync, first and second segments one quantum per tick,
// applies hard synchronization and resynchronization (one per bit, bounded
// by the jump width) and flags when the sampler must take a bus level.
// Assumes: configuration is stable while the bus is active; segment lengths are
// captured when the sync quantum ends (or on hard sync).
module can_bt_seq
    import can_bt_pkg::*;
#(
    parameter int S1W = 4,
    parameter int S2W = 3,
    parameter int CW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tq_tick,
    input  logic           fall_edge,
    input  logic           bus_idle,
    input  logic [S1W-1:0] seg1_cfg,
    input  logic [S2W-1:0] seg2_cfg,
    input  logic [1:0]     sjw_cfg,
    input  logic           triple_en,
    output seg_e           seg,
    output logic           take_smp,
    output logic           final_smp,
    output logic           tx_stb
);

    seg_e          seg_q, seg_n;
    logic [CW-1:0] idx_q, idx_n;
    logic [CW-1:0] len1_q, len1_n;
    logic [CW-1:0] len2_q, len2_n;
    logic          used_q, used_n;
    logic          enter_sync;
    logic          tx_q;

    logic [CW-1:0] nom1, nom2, jump;
    logic [CW-1:0] pos1, rem2, grow, cut;

    // Nominal lengths and the jump width, in quanta.
    always_comb begin
        nom1 = CW'(seg1_cfg) + CW'(1) + (triple_en ? CW'(2) : CW'(0));
        nom2 = CW'(seg2_cfg) + CW'(1);
        jump = CW'(sjw_cfg) + CW'(1);
    end

    // Phase error magnitudes and their jump-limited corrections.
    always_comb begin
        pos1 = idx_q + CW'(1);
        rem2 = len2_q - CW'(1) - idx_q;
        grow = (pos1 < jump) ? pos1 : jump;
        cut  = (rem2 < jump) ? rem2 : jump;
    end

    // Next-quantum decision made at each tick.
    always_comb begin
        seg_n      = seg_q;
        idx_n      = idx_q;
        len1_n     = len1_q;
        len2_n     = len2_q;
        used_n     = used_q;
        take_smp   = 1'b0;
        final_smp  = 1'b0;
        enter_sync = 1'b0;
        if (tq_tick) begin
            if (fall_edge && bus_idle) begin
                seg_n  = SEG_FIRST;
                idx_n  = '0;
                len1_n = nom1;
                len2_n = nom2;
                used_n = 1'b1;
            end else begin
                case (seg_q)
                    SEG_SYNC: begin
                        seg_n  = SEG_FIRST;
                        idx_n  = '0;
                        len1_n = nom1;
                        len2_n = nom2;
                        used_n = fall_edge;
                    end
                    SEG_FIRST: begin
                        if (fall_edge && !used_q) begin
                            len1_n = len1_q + grow;
                        end
                        used_n    = used_q | fall_edge;
                        final_smp = (pos1 == len1_n);
                        take_smp  = triple_en ? ((idx_q + CW'(3)) >= len1_n) : final_smp;
                        if (final_smp) begin
                            seg_n = SEG_SECOND;
                            idx_n = '0;
                        end else begin
                            idx_n = pos1;
                        end
                    end
                    SEG_SECOND: begin
                        if (fall_edge && !used_q && (rem2 != '0)) begin
                            len2_n = len2_q - cut;
                            used_n = 1'b1;
                        end
                        if (pos1 >= len2_n) begin
                            seg_n      = SEG_SYNC;
                            idx_n      = '0;
                            used_n     = 1'b0;
                            enter_sync = 1'b1;
                        end else begin
                            idx_n = pos1;
                        end
                    end
                    default: begin
                        seg_n = SEG_SYNC;
                        idx_n = '0;
                    end
                endcase
            end
        end
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q  <= SEG_SYNC;
            idx_q  <= '0;
            len1_q <= '0;
            len2_q <= '0;
            used_q <= 1'b0;
            tx_q   <= 1'b0;
        end else begin
            seg_q  <= seg_n;
            idx_q  <= idx_n;
            len1_q <= len1_n;
            len2_q <= len2_n;
            used_q <= used_n;
            tx_q   <= enter_sync;
        end
    end

    assign seg    = seg_q;
    assign tx_stb = tx_q;

endmodule

// File: rtl/can_bt_sampler.sv
// Bus sampler: keeps the last three taken bus levels and produces the bit value
// at the sample point, either the latest level or the majority of three.
// Assumes: take and final requests are already qualified by the quantum tick.
module can_bt_sampler
    import can_bt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_smp,
    input  logic final_smp,
    input  logic triple_en,
    input  logic rx_in,
    output logic sample_stb,
    output logic rx_bit
);

    logic [2:0] hist_q;
    logic       stb_q;
    logic       bit_q;

    // Shift in each requested bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= 3'b111;
        end else if (take_smp) begin
            hist_q <= {hist_q[1:0], rx_in};
        end
    end

    // Update the bit value and strobe at the sample point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
            bit_q <= 1'b1;
        end else begin
            stb_q <= final_smp;
            if (final_smp) begin
                bit_q <= triple_en ? vote3(hist_q[1], hist_q[0], rx_in) : rx_in;
            end
        end
    end

    assign sample_stb = stb_q;
    assign rx_bit     = bit_q;

endmodule

// File: rtl/can_bt_top.sv
// CAN bit timing top: edge detector, segment sequencer and bus sampler.
// Assumes: tq_tick is a single-clock pulse per quantum from an external
// prescaler; configuration inputs change only while the bus is idle.
module can_bt_top
    import can_bt_pkg::*;
#(
    parameter int S1W = 4,
    parameter int S2W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tq_tick,
    input  logic           rx_in,
    input  logic           bus_idle,
    input  logic [S1W-1:0] seg1_cfg,
    input  logic [S2W-1:0] seg2_cfg,
    input  logic [1:0]     sjw_cfg,
    input  logic           triple_en,
    output logic [1:0]     seg_id,
    output logic           sample_stb,
    output logic           rx_bit,
    output logic           tx_stb
);

    localparam int WMAX = (S1W > S2W) ? S1W : S2W;
    localparam int CW   = $clog2((1 << WMAX) + 16);

    logic fall_edge;
    logic take_smp;
    logic final_smp;
    seg_e seg;

    can_bt_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .tq_tick   (tq_tick),
        .rx_in     (rx_in),
        .fall_edge (fall_edge)
    );

    can_bt_seq #(
        .S1W (S1W),
        .S2W (S2W),
        .CW  (CW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tq_tick   (tq_tick),
        .fall_edge (fall_edge),
        .bus_idle  (bus_idle),
        .seg1_cfg  (seg1_cfg),
        .seg2_cfg  (seg2_cfg),
        .sjw_cfg   (sjw_cfg),
        .triple_en (triple_en),
        .seg       (seg),
        .take_smp  (take_smp),
        .final_smp (final_smp),
        .tx_stb    (tx_stb)
    );

    can_bt_sampler u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_smp   (take_smp),
        .final_smp  (final_smp),
        .triple_en  (triple_en),
        .rx_in      (rx_in),
        .sample_stb (sample_stb),
        .rx_bit     (rx_bit)
    );

    assign seg_id = seg;

endmodule

// File: rtl/can_bt_chk.sv
// Port-level checker for can_bt_top, attached by bind below.
// Assumes: synchronous active-low reset.
module can_bt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tq_tick,
    input logic [1:0] seg_id,
    input logic       sample_stb,
    input logic       rx_bit,
    input logic       tx_stb
);

    // R2
    seg_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_id != 2'd3);

    // R2
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tq_tick |=> $stable(seg_id));

    // R2
    sync_one_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_tick && seg_id == 2'd0) |=> (seg_id == 2'd1));

    // R4
    tx_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |-> (seg_id == 2'd0));

    // R5
    smp_from_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> ($past(seg_id) == 2'd1 && $past(tq_tick)));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && tx_stb));

    // R12
    bit_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_bit) |-> sample_stb);

endmodule

bind can_bt_top can_bt_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tq_tick    (tq_tick),
    .seg_id     (seg_id),
    .sample_stb (sample_stb),
    .rx_bit     (rx_bit),
    .tx_stb     (tx_stb)
);

// File: tb/can_bt_top_tb_top.sv
`timescale 1ns/1ps
// Bench for can_bt_top: a position-based reference model checked every clock,
// plus directed bit-length and sampling checks.
module can_bt_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tq_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       bus_idle = 1'b0;
    logic [3:0] seg1_cfg = 4'd4;
    logic [2:0] seg2_cfg = 3'd2;
    logic [1:0] sjw_cfg = 2'd1;
    logic       triple_en = 1'b0;
    logic [1:0] seg_id;
    logic       sample_stb, rx_bit, tx_stb;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    string cur_req = "R2";

    // Reference model state: position in bit (0 = sync), segment lengths.
    int m_pos = 0, m_t1 = 0, m_t2 = 0;
    bit m_used = 0, m_prv = 1, m_bit = 1, m_ss = 0, m_tx = 0;
    bit m_hist[$] = '{1'b1, 1'b1, 1'b1};
    int qn = 0, last_tx = 0, bitlen = 0;

    always #10 clk = ~clk;

    can_bt_top dut_i (
        .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .rx_in(rx_in),
        .bus_idle(bus_idle), .seg1_cfg(seg1_cfg), .seg2_cfg(seg2_cfg),
        .sjw_cfg(sjw_cfg), .triple_en(triple_en), .seg_id(seg_id),
        .sample_stb(sample_stb), .rx_bit(rx_bit), .tx_stb(tx_stb)
    );

    function automatic int mn(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance the model by one clock with the given inputs.
    task automatic model(input bit tk, input bit rx, input bit idle);
        bit edg;
        int nom1, nom2, jw, rem, s;
        m_ss = 0;
        m_tx = 0;
        if (!tk) return;
        edg   = m_prv && !rx;
        m_prv = rx;
        nom1  = int'(seg1_cfg) + 1 + (triple_en ? 2 : 0);
        nom2  = int'(seg2_cfg) + 1;
        jw    = int'(sjw_cfg) + 1;
        if (edg && idle) begin
            m_pos = 1; m_t1 = nom1; m_t2 = nom2; m_used = 1;
        end else if (m_pos == 0) begin
            m_used = edg; m_pos = 1; m_t1 = nom1; m_t2 = nom2;
        end else if (m_pos <= m_t1) begin
            if (edg && !m_used) m_t1 += mn(m_pos, jw);
            if (edg) m_used = 1;
            if (triple_en ? (m_pos >= m_t1 - 2) : (m_pos == m_t1)) begin
                m_hist.push_back(rx);
                void'(m_hist.pop_front());
            end
            if (m_pos == m_t1) begin
                m_ss = 1;
                s = int'(m_hist[0]) + int'(m_hist[1]) + int'(m_hist[2]);
                m_bit = triple_en ? (s >= 2) : rx;
            end
            m_pos++;
        end else begin
            rem = m_t1 + m_t2 - m_pos;
            if (edg && !m_used && rem > 0) begin
                m_t2 -= mn(rem, jw);
                m_used = 1;
            end
            if (m_pos >= m_t1 + m_t2) begin
                m_pos = 0; m_used = 0; m_tx = 1;
            end else begin
                m_pos++;
            end
        end
    endtask

    // One clock: drive at negedge, compare all outputs at the next negedge.
    task automatic step(input bit tk, input bit rx, input bit idle);
        int es;
        tq_tick = tk; rx_in = rx; bus_idle = idle;
        model(tk, rx, idle);
        if (tk) qn++;
        @(posedge clk);
        @(negedge clk);
        es = (m_pos == 0) ? 0 : ((m_pos <= m_t1) ? 1 : 2);
        n_tests++;
        if (int'(seg_id) != es || sample_stb != m_ss || tx_stb != m_tx || rx_bit != m_bit) begin
            n_fail++;
            $display("FAIL %s (R2/R4/R5/R12 model): actual seg=%0d smp=%0d tx=%0d bit=%0d expected seg=%0d smp=%0d tx=%0d bit=%0d",
                     cur_req, seg_id, sample_stb, tx_stb, rx_bit, es, m_ss, m_tx, m_bit);
        end
        if (tx_stb) begin
            bitlen  = qn - last_tx;
            last_tx = qn;
        end
    endtask

    task automatic qrun(input int n, input bit rx, input bit idle);
        for (int i = 0; i < n; i++) begin
            step(1'b1, rx, idle);
            step(1'b0, rx, idle);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(seg_id == 2'd0 && !sample_stb && !tx_stb && rx_bit, "R1",
            {seg_id, sample_stb, tx_stb, rx_bit}, 1);

        // R3 nominal bit of 9 quanta, R5 single sample
        cur_req = "R3";
        qrun(30, 1'b1, 1'b0);
        chk(bitlen == 9, "R3", bitlen, 9);
        cur_req = "R5";
        qrun(20, 1'b1, 1'b0);
        chk(rx_bit == 1'b1, "R5", rx_bit, 1);

        // R8 hard sync, R7 rising edge ignored, R9 lengthening by min(3,2)
        cur_req = "R8";
        qrun(3, 1'b1, 1'b1);
        qrun(1, 1'b0, 1'b1);
        chk(seg_id == 2'd1, "R8", seg_id, 1);
        cur_req = "R7";
        qrun(11, 1'b1, 1'b0);
        cur_req = "R9";
        qrun(1, 1'b0, 1'b0);
        qrun(7, 1'b0, 1'b0);
        chk(bitlen == 11, "R9", bitlen, 11);

        // R9 lengthening by min(1,2)
        qrun(2, 1'b1, 1'b1);
        qrun(1, 1'b0, 1'b1);
        qrun(9, 1'b1, 1'b0);
        qrun(1, 1'b0, 1'b0);
        qrun(8, 1'b0, 1'b0);
        chk(bitlen == 10, "R9", bitlen, 10);

        // R10 full shortening: next quantum is sync
        cur_req = "R10";
        qrun(2, 1'b1, 1'b1);
        qrun(1, 1'b0, 1'b1);
        qrun(14, 1'b1, 1'b0);
        qrun(1, 1'b0, 1'b0);
        chk(bitlen == 7, "R10", bitlen, 7);

        // R10 partial shortening with jump width 1
        sjw_cfg = 2'd0;
        qrun(2, 1'b1, 1'b1);
        qrun(1, 1'b0, 1'b1);
        qrun(14, 1'b1, 1'b0);
        qrun(2, 1'b0, 1'b0);
        chk(bitlen == 8, "R10", bitlen, 8);

        // R11 second edge in the same bit is ignored
        cur_req = "R11";
        sjw_cfg = 2'd1;
        qrun(2, 1'b1, 1'b1);
        qrun(1, 1'b0, 1'b1);
        qrun(9, 1'b1, 1'b0);
        qrun(1, 1'b0, 1'b0);
        qrun(5, 1'b1, 1'b0);
        qrun(1, 1'b0, 1'b0);
        qrun(2, 1'b0, 1'b0);
        chk(bitlen == 10, "R11", bitlen, 10);

        // R6 majority of 0,0,1 and 11-quantum bit
        cur_req = "R6";
        triple_en = 1'b1;
        qrun(2, 1'b1, 1'b1);
        qrun(1, 1'b0, 1'b1);
        qrun(4, 1'b1, 1'b0);
        qrun(2, 1'b0, 1'b0);
        qrun(1, 1'b1, 1'b0);
        chk(rx_bit == 1'b0, "R6", rx_bit, 0);
        qrun(14, 1'b1, 1'b0);
        chk(bitlen == 11, "R6", bitlen, 11);
        triple_en = 1'b0;

        // Randomized stress against the model, several configurations
        cur_req = "R12";
        for (int c = 0; c < 8; c++) begin
            bit rx_r, idle_r;
            seg1_cfg  = 4'($urandom_range(0, 15));
            seg2_cfg  = 3'($urandom_range(0, 7));
            sjw_cfg   = 2'($urandom_range(0, 3));
            triple_en = 1'($urandom_range(0, 1));
            rx_r = 1'b1;
            idle_r = 1'b0;
            for (int i = 0; i < 1500; i++) begin
                if ($urandom_range(0, 9) == 0) rx_r = ~rx_r;
                if ($urandom_range(0, 99) == 0) idle_r = ~idle_r;
                step(1'($urandom_range(0, 1)), rx_r, idle_r);
            end
        end
        finish_run();
    end

endmodule